// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial slave (enable, serial clock, serial data) that loads a bank of 24-bit configuration registers. Each frame begins with an 8-bit register address and continues with one or more 24-bit data words. Address and data arrive least significant bit first. Each extra complete word in a frame goes to the next higher address, so a long burst can fill a run of registers with a single address phase. The three serial wires and the sync input are brought into the system clock domain by two-flop synchronisers. Edges are detected only after synchronisation.

Every register has a shadow copy and an active copy. A serial write lands in the shadow copy and marks that register pending. Most registers move their pending value to the active copy on the next falling edge of the frame/line sync input. A parameter selects a few registers that move at the end of the serial frame instead. An update-hold register blocks all sync-driven transfers while its bit 0 is set. A software reset register returns every register to its default when bit 0 is written as 1. The active bank is the only output, presented as one flat vector.

Top module: `ser_cfg_regs`

## Requirements
- R1: After reset, register i shows DEF_BASE+i in the active bank, except the software reset register (address 1) and the update-hold register (address 2), which show 0.
- R2: A frame carries 8 address bits and then 24 data bits per word. Both fields are sent least significant bit first and sampled on rising edges of the serial clock while enable is high.
- R3: In a frame with several complete 24-bit words, word k goes to the start address plus k.
- R4: A data word cut short by enable going low leaves its target register unchanged. Earlier complete words of the same frame are still written.
- R5: A sync-class register keeps its old active value after a write until the next falling edge of the sync input. On that edge it takes the written value.
- R6: Load-class registers take a written value into the active bank when enable falls at the end of the frame, with no sync edge. These are the registers selected by LOAD_MASK (default: address 3) plus the update-hold register.
- R7: While bit 0 of the active update-hold register is 1, sync edges move no pending value. Once it is written back to 0, the pending values move on the next sync falling edge.
- R8: Only bit 0 of the update-hold register is stored. The upper 23 written bits are ignored.
- R9: A complete write with bit 0 set to the software reset register (address 1) returns every register to its R1 value and clears every pending write. That register then reads 0.
- R10: Writes to addresses at or above NUM_REGS change no register, including words that a burst carries past the last register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial frame enable, active high |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data, LSB first |
| sync_n | input | 1 | Frame/line sync; falling edge commits pending writes |
| cfg_active | output | NUM_REGS*24 | Active register bank, register i at bits [24*i +: 24] |

## Verification
The hardest state to reach is a pending write caught between the two commit mechanisms. The shadow copy holds a new value, but the active copy must not yet show it. This happens while hold is raised, and again just after hold is cleared but before the next sync edge. The stimulus sets hold through a load-class write, then writes a sync-class register and pulses sync. It clears hold with a word whose upper bits are all ones and checks before and after the following sync edge. A second scenario leaves a write pending without a sync edge and then issues a software reset. A later sync edge must not bring the discarded value back.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 24;

  typedef struct packed {
    logic [CFG_AW-1:0] addr;
    logic [CFG_DW-1:0] data;
  } cfg_beat_t;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int           W     = 1,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_V;
      sync_q <= RST_V;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ser_cfg_rx.sv
module ser_cfg_rx
  import ser_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_s,
  input  logic      sclk_s,
  input  logic      sdat_s,
  output logic      wr_vld,
  output cfg_beat_t wr_beat,
  output logic      frame_end
);
  localparam int CNT_W   = $clog2(CFG_DW);
  localparam int A_LAST  = CFG_AW - 1;
  localparam int D_LAST  = CFG_DW - 1;

  logic              sclk_d, en_d;
  logic              addr_done_q, addr_done_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [CFG_AW-1:0] ash_q, ash_n;
  logic [CFG_DW-1:0] dsh_q, dsh_n;
  logic [CFG_AW-1:0] waddr_q, waddr_n;
  logic              wr_n;
  logic              sclk_rise;
  logic              fe_n;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign fe_n      = en_d & ~en_s;

  always_comb begin
    addr_done_n = addr_done_q;
    cnt_n       = cnt_q;
    ash_n       = ash_q;
    dsh_n       = dsh_q;
    waddr_n     = waddr_q;
    wr_n        = 1'b0;
    if (!en_s) begin
      addr_done_n = 1'b0;
      cnt_n       = '0;
    end else if (sclk_rise) begin
      if (!addr_done_q) begin
        ash_n = {sdat_s, ash_q[CFG_AW-1:1]};
        if (cnt_q == CNT_W'(A_LAST)) begin
          addr_done_n = 1'b1;
          cnt_n       = '0;
          waddr_n     = ash_n;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        dsh_n = {sdat_s, dsh_q[CFG_DW-1:1]};
        if (cnt_q == CNT_W'(D_LAST)) begin
          wr_n    = 1'b1;
          cnt_n   = '0;
          waddr_n = waddr_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d       <= 1'b0;
      en_d         <= 1'b0;
      addr_done_q  <= 1'b0;
      cnt_q        <= '0;
      ash_q        <= '0;
      dsh_q        <= '0;
      waddr_q      <= '0;
      wr_vld       <= 1'b0;
      wr_beat      <= '0;
      frame_end    <= 1'b0;
    end else begin
      sclk_d       <= sclk_s;
      en_d         <= en_s;
      addr_done_q  <= addr_done_n;
      cnt_q        <= cnt_n;
      ash_q        <= ash_n;
      dsh_q        <= dsh_n;
      waddr_q      <= waddr_n;
      wr_vld       <= wr_n;
      frame_end    <= fe_n;
      if (wr_n) begin
        wr_beat.addr <= waddr_q;
        wr_beat.data <= dsh_n;
      end
    end
  end

  // R4: a word is only emitted from inside an active frame
  p_wr_inside_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> en_d);
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
#(
  parameter int                 NUM_REGS  = 16,
  parameter int                 RST_ADDR  = 1,
  parameter int                 HOLD_ADDR = 2,
  parameter logic [NUM_REGS-1:0] LOAD_MASK = 16'h0008,
  parameter logic [CFG_DW-1:0]  DEF_BASE  = 24'hA50000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_vld,
  input  cfg_beat_t                        wr_beat,
  input  logic                             frame_end,
  input  logic                             sync_fall,
  output logic [NUM_REGS-1:0][CFG_DW-1:0]  act
);
  logic swr;
  logic hold_act;

  assign swr      = wr_vld && (wr_beat.addr == CFG_AW'(RST_ADDR)) && wr_beat.data[0];
  assign hold_act = act[HOLD_ADDR][0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam bit IS_RST  = (i == RST_ADDR);
    localparam bit IS_HOLD = (i == HOLD_ADDR);
    localparam bit IS_LOAD = LOAD_MASK[i] || IS_HOLD;
    localparam logic [CFG_DW-1:0] MASK = IS_HOLD ? CFG_DW'(1) : '1;
    localparam logic [CFG_DW-1:0] DEF  = (IS_RST || IS_HOLD) ? '0 : CFG_DW'(DEF_BASE + CFG_DW'(i));

    if (IS_RST) begin : g_swr
      assign act[i] = '0;
    end else begin : g_store
      logic [CFG_DW-1:0] sh_q, sh_n, ac_q, ac_n;
      logic              pd_q, pd_n;
      logic              hit, xfer;

      assign hit  = wr_vld && (wr_beat.addr == CFG_AW'(i));
      if (IS_LOAD) begin : g_ld
        assign xfer = frame_end;
      end else begin : g_sy
        assign xfer = sync_fall && !hold_act;
      end

      always_comb begin
        sh_n = sh_q;
        pd_n = pd_q;
        ac_n = ac_q;
        if (xfer && pd_q) begin
          ac_n = sh_q;
          pd_n = 1'b0;
        end
        if (hit) begin
          sh_n = wr_beat.data & MASK;
          pd_n = 1'b1;
        end
        if (swr) begin
          sh_n = DEF;
          ac_n = DEF;
          pd_n = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= DEF;
          ac_q <= DEF;
          pd_q <= 1'b0;
        end else begin
          sh_q <= sh_n;
          ac_q <= ac_n;
          pd_q <= pd_n;
        end
      end

      assign act[i] = ac_q;

      // R9: software reset restores the default on the next cycle
      p_swr_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (act[i] == DEF));

      if (IS_LOAD) begin : g_ld_chk
        // R6: load-class registers move only at frame end
        p_load_frame_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (!frame_end && !swr) |=> $stable(act[i]));
      end else begin : g_sy_chk
        // R5: sync-class registers move only on a sync falling edge
        p_sync_edge_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (!sync_fall && !swr) |=> $stable(act[i]));
        // R7: hold freezes sync-class registers
        p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (hold_act && !swr) |=> $stable(act[i]));
      end
    end
  end
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
  import ser_cfg_pkg::*;
#(
  parameter int                  NUM_REGS  = 16,
  parameter int                  RST_ADDR  = 1,
  parameter int                  HOLD_ADDR = 2,
  parameter logic [NUM_REGS-1:0] LOAD_MASK = 16'h0008,
  parameter logic [CFG_DW-1:0]   DEF_BASE  = 24'hA50000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_en,
  input  logic                         ser_clk,
  input  logic                         ser_dat,
  input  logic                         sync_n,
  output logic [NUM_REGS*CFG_DW-1:0]   cfg_active
);
  logic [3:0] raw_in, syn_in;
  logic       en_s, sclk_s, sdat_s, syncn_s, syncn_d;
  logic       sync_fall;
  logic       wr_vld, frame_end;
  cfg_beat_t  wr_beat;
  logic [NUM_REGS-1:0][CFG_DW-1:0] act;

  assign raw_in = {sync_n, ser_en, ser_clk, ser_dat};

  ser_cfg_sync #(.W(4), .RST_V(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign {syncn_s, en_s, sclk_s, sdat_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncn_d <= 1'b1;
    else        syncn_d <= syncn_s;
  end

  assign sync_fall = syncn_d & ~syncn_s;

  ser_cfg_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .sclk_s    (sclk_s),
    .sdat_s    (sdat_s),
    .wr_vld    (wr_vld),
    .wr_beat   (wr_beat),
    .frame_end (frame_end)
  );

  ser_cfg_bank #(
    .NUM_REGS  (NUM_REGS),
    .RST_ADDR  (RST_ADDR),
    .HOLD_ADDR (HOLD_ADDR),
    .LOAD_MASK (LOAD_MASK),
    .DEF_BASE  (DEF_BASE)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_vld    (wr_vld),
    .wr_beat   (wr_beat),
    .frame_end (frame_end),
    .sync_fall (sync_fall),
    .act       (act)
  );

  assign cfg_active = act;
endmodule

// File: tb/tb_ser_cfg_regs.sv
module tb_ser_cfg_regs;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n, ser_en, ser_clk, ser_dat, sync_n;
  logic [NR*24-1:0] cfg_active;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ser_cfg_regs dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_en     (ser_en),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .sync_n     (sync_n),
    .cfg_active (cfg_active)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int idx, input logic [23:0] exp, input string req);
    logic [23:0] got;
    got = cfg_active[idx*24 +: 24];
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s reg%0d actual=%06h expected=%06h", req, idx, got, exp);
    end
  endtask

  task automatic sbit(input logic b);
    ser_dat = b;
    wclk(4);
    ser_clk = 1'b1;
    wclk(4);
    ser_clk = 1'b0;
  endtask

  task automatic frame(input logic [7:0] a, input int nw, input logic [23:0] w0,
                       input logic [23:0] w1, input logic [23:0] w2, input int extra);
    logic [23:0] w;
    ser_en = 1'b1;
    wclk(4);
    for (int i = 0; i < 8; i++) sbit(a[i]);
    for (int k = 0; k < nw; k++) begin
      w = (k == 0) ? w0 : (k == 1) ? w1 : w2;
      for (int i = 0; i < 24; i++) sbit(w[i]);
    end
    for (int i = 0; i < extra; i++) sbit(1'b1);
    wclk(4);
    ser_en = 1'b0;
    wclk(10);
  endtask

  task automatic pulse_sync();
    sync_n = 1'b0;
    wclk(4);
    sync_n = 1'b1;
    wclk(8);
  endtask

  task automatic t_reset();
    chk(0, 24'hA50000, "R1");
    chk(5, 24'hA50005, "R1");
    chk(15, 24'hA5000F, "R1");
    chk(1, 24'h000000, "R1");
    chk(2, 24'h000000, "R1");
  endtask

  task automatic t_single();
    frame(8'h05, 1, 24'h123456, 0, 0, 0);
    chk(5, 24'hA50005, "R5");
    pulse_sync();
    chk(5, 24'h123456, "R2");
  endtask

  task automatic t_trunc();
    frame(8'h06, 0, 0, 0, 0, 10);
    pulse_sync();
    chk(6, 24'hA50006, "R4");
    frame(8'h06, 1, 24'h0F0F0F, 0, 0, 12);
    pulse_sync();
    chk(6, 24'h0F0F0F, "R4");
    chk(7, 24'hA50007, "R4");
  endtask

  task automatic t_burst();
    frame(8'h08, 3, 24'h111111, 24'h222222, 24'h333333, 0);
    pulse_sync();
    chk(8, 24'h111111, "R3");
    chk(9, 24'h222222, "R3");
    chk(10, 24'h333333, "R3");
  endtask

  task automatic t_load();
    frame(8'h03, 1, 24'hABCDEF, 0, 0, 0);
    chk(3, 24'hABCDEF, "R6");
  endtask

  task automatic t_hold();
    frame(8'h02, 1, 24'h000001, 0, 0, 0);
    chk(2, 24'h000001, "R7");
    frame(8'h07, 1, 24'h777777, 0, 0, 0);
    pulse_sync();
    chk(7, 24'hA50007, "R7");
    frame(8'h02, 1, 24'hFFFFFE, 0, 0, 0);
    chk(2, 24'h000000, "R8");
    chk(7, 24'hA50007, "R7");
    pulse_sync();
    chk(7, 24'h777777, "R7");
  endtask

  task automatic t_range();
    frame(8'h20, 1, 24'hDEAD00, 0, 0, 0);
    pulse_sync();
    chk(0, 24'hA50000, "R10");
    frame(8'h0F, 2, 24'hF1F1F1, 24'hF2F2F2, 0, 0);
    pulse_sync();
    chk(15, 24'hF1F1F1, "R10");
    chk(0, 24'hA50000, "R10");
  endtask

  task automatic t_swr();
    frame(8'h0B, 1, 24'hBBBBBB, 0, 0, 0);
    frame(8'h01, 1, 24'h000001, 0, 0, 0);
    chk(5, 24'hA50005, "R9");
    chk(3, 24'hA50003, "R9");
    chk(1, 24'h000000, "R9");
    pulse_sync();
    chk(11, 24'hA5000B, "R9");
  endtask

  initial begin
    rst_n = 1'b0; ser_en = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; sync_n = 1'b1;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_single();
    t_trunc();
    t_burst();
    t_load();
    t_hold();
    t_range();
    t_swr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule